// File: doc/BRIEF.md
# Byte-Stream DMA Channel Controller

This block is a single DMA channel. It moves 8-bit data from one of two serial-receive byte sources into one of four external-bus memory banks. Software uses a small register port to program a total byte count and a half-transfer count, pick the source and the bank, and set an enable bit. While enabled, the channel forwards every byte that the selected source offers and the bus side accepts. Each forwarded byte raises a one-hot strobe for the chosen bank. The channel counts the bytes as they move.

After the programmed number of bytes the channel sets a sticky transfer-complete flag and clears its own enable bit in the same cycle. A second, independent count sets a sticky half-transfer flag part-way through the transfer. Its reset value is the all-ones value, so after reset it does not fire unless software reprograms it. Each flag has its own interrupt enable, and the interrupt line is the OR of each flag masked by its enable. While the channel runs, both count registers ignore writes and read back the number of bytes still to move.

The control is a two-state machine:
- `ST_IDLE` is the state with the enable bit clear.
- `ST_XFER` is the running state.
- Transition T_START goes from `ST_IDLE` to `ST_XFER` when software writes a 1 to the enable bit. It also clears the byte counter.
- Transition T_DONE goes from `ST_XFER` to `ST_IDLE` when the final byte is accepted.
- Transition T_ABORT goes from `ST_XFER` to `ST_IDLE` when software writes a 0 to the enable bit.
- With none of these, `ST_XFER` stays in `ST_XFER` and `ST_IDLE` stays in `ST_IDLE`.

Top module: `bsdma_chan`

## Requirements
- R1: After reset the following read as zero: the control register, the total count, the interrupt enables, both flags and `irq`. The half count reads 0xFFFFFFF.
- R2: The register map is:
  - Address 0: control. Bit 0 is enable, bit 1 is source select (0 = source 0, 1 = source 1), bits 3:2 are the bank (00 = bank 0 up to 11 = bank 3).
  - Address 1: total count N−1.
  - Address 2: half count.
  - Address 3: interrupt enables. Bit 0 enables the complete interrupt, bit 1 the half interrupt.
  - Address 4: flags. Bit 0 is complete, bit 1 is half.
  - Address 5: flag clear. It is write-only and reads 0.
- R3: While running, a byte moves in a cycle only when the selected source's `src_valid` bit and `bus_ready` are both high. In that cycle `bus_wr_en` is high, `bus_wdata` carries that source's byte, and `src_ready` is high only for the selected source. The other source's handshake has no effect.
- R4: In each byte-write cycle `bank_strobe` has exactly the bit of the selected bank set. Bit n is bank n. At all other times `bank_strobe` is 0.
- R5: With total count CNT, exactly CNT+1 bytes move. In the cycle after the final byte is accepted, the complete flag reads 1 and the enable bit reads 0. After that no further byte moves.
- R6: The half flag sets once HTCNT+1 bytes have moved. With the reset value 0xFFFFFFF it stays 0 for any shorter transfer.
- R7: While running, writes to addresses 1 and 2 are ignored. Both addresses read CNT minus the number of bytes moved so far. When idle, they read the programmed values.
- R8: The flags are sticky. Writing 1 to a bit at address 5 clears that flag. When a clear and a hardware set of the same flag fall in the same cycle, the set wins.
- R9: `irq` is high exactly when (complete flag AND its enable) OR (half flag AND its enable) is true.
- R10: Writing 0 to the enable bit while running stops the transfer. No further byte moves and the complete flag is not set.
- R11: Each 0-to-1 change of the enable bit restarts the byte count at 0. A transfer started after an abort therefore moves the full CNT+1 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 28 | Register write data |
| reg_rdata | output | 28 | Register read data for `reg_addr` (combinational) |
| src_valid | input | 2 | Byte-valid, one bit per source |
| src_data | input | 16 | Byte of each source; source n in bits 8n+7:8n |
| src_ready | output | 2 | Byte taken, one bit per source |
| bus_ready | input | 1 | Bus side can accept a byte write |
| bus_wr_en | output | 1 | Byte write to the bus this cycle |
| bus_wdata | output | 8 | Byte being written |
| bank_strobe | output | 4 | One-hot bank select of the current byte write |
| irq | output | 1 | Interrupt request |

## Verification
Two cases can fall in the same cycle. In the first, the final byte is accepted in the same cycle that software writes the flag-clear register. In the second, the half count equals the total count, so both flags set on the same byte. The bench provokes both with a single-byte transfer (total 0, half 0). It presents the byte and drives a clear write of both flag bits in one cycle. It then expects both flags to read 1, the enable bit to read 0, and `irq` to be high. No later byte may move.

// File: rtl/bsdma_pkg.sv
package bsdma_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } chan_state_t;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_TOTAL = 3'd1;
    localparam logic [REG_AW-1:0] A_HALF  = 3'd2;
    localparam logic [REG_AW-1:0] A_IRQEN = 3'd3;
    localparam logic [REG_AW-1:0] A_STAT  = 3'd4;
    localparam logic [REG_AW-1:0] A_CLR   = 3'd5;
endpackage

// File: rtl/bsdma_route.sv
module bsdma_route #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned NUM_BANK = 4,
    localparam int unsigned SRC_W   = $clog2(NUM_SRC),
    localparam int unsigned BANK_W  = $clog2(NUM_BANK)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        running,
    input  logic [SRC_W-1:0]            src_sel,
    input  logic [BANK_W-1:0]           bank_sel,
    input  logic [NUM_SRC-1:0]          src_valid,
    input  logic [NUM_SRC*DATA_W-1:0]   src_data,
    input  logic                        bus_ready,
    output logic                        beat,
    output logic [NUM_SRC-1:0]          src_ready,
    output logic [DATA_W-1:0]           bus_wdata,
    output logic [NUM_BANK-1:0]         bank_strobe
);
    always_comb begin
        beat      = running && src_valid[src_sel] && bus_ready;
        bus_wdata = src_data[src_sel*DATA_W +: DATA_W];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_ready[g] = beat && (src_sel == SRC_W'(g));
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        assign bank_strobe[b] = beat && (bank_sel == BANK_W'(b));
    end

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready)); // R3
    AST_STROBE_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> $countones(bank_strobe) == 1); // R4
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> bank_strobe == '0); // R4
endmodule

// File: rtl/bsdma_fsm.sv
module bsdma_fsm
    import bsdma_pkg::*;
#(
    parameter int unsigned CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             beat,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] htcnt,
    output logic             running,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             tc_set,
    output logic             ht_set
);
    chan_state_t state_q, state_d;
    logic        last_beat;

    assign last_beat = beat && (cur_cnt == cnt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_XFER;           // T_START
            ST_XFER: begin
                if (last_beat)     state_d = ST_IDLE;            // T_DONE
                else if (stop_req) state_d = ST_IDLE;            // T_ABORT
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = 1'b0;
        tc_set  = 1'b0;
        ht_set  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                running = 1'b1;
                tc_set  = last_beat;
                ht_set  = beat && (cur_cnt == htcnt);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cur_cnt <= '0;
        else if (state_q == ST_IDLE && start_req) cur_cnt <= '0;
        else if (running && beat)                cur_cnt <= cur_cnt + 1'b1;
    end

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_set |=> !running); // R5
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cur_cnt <= cnt); // R5
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop_req && !beat) |=> !running); // R10
    AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start_req) |=> (running && cur_cnt == '0)); // R11
endmodule

// File: rtl/bsdma_regs.sv
module bsdma_regs
    import bsdma_pkg::*;
#(
    parameter int unsigned CNT_W    = 28,
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned NUM_BANK = 4,
    localparam int unsigned SRC_W   = $clog2(NUM_SRC),
    localparam int unsigned BANK_W  = $clog2(NUM_BANK),
    localparam int unsigned BANK_LSB = 1 + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              running,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic              tc_set,
    input  logic              ht_set,
    output logic              start_req,
    output logic              stop_req,
    output logic [SRC_W-1:0]  src_sel,
    output logic [BANK_W-1:0] bank_sel,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  htcnt_q,
    output logic              irq
);
    logic tc_q, ht_q, tc_ie_q, ht_ie_q;
    logic ctrl_hit, clr_hit;
    logic [CNT_W-1:0] remaining;

    assign ctrl_hit  = reg_we && (reg_addr == A_CTRL);
    assign clr_hit   = reg_we && (reg_addr == A_CLR);
    assign start_req = ctrl_hit && reg_wdata[0] && !running;
    assign stop_req  = ctrl_hit && !reg_wdata[0];
    assign remaining = cnt_q - cur_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel  <= '0;
            bank_sel <= '0;
            cnt_q    <= '0;
            htcnt_q  <= '1;
            tc_ie_q  <= 1'b0;
            ht_ie_q  <= 1'b0;
            tc_q     <= 1'b0;
            ht_q     <= 1'b0;
        end else begin
            if (ctrl_hit) begin
                src_sel  <= reg_wdata[1 +: SRC_W];
                bank_sel <= reg_wdata[BANK_LSB +: BANK_W];
            end
            if (reg_we && reg_addr == A_TOTAL && !running) cnt_q   <= reg_wdata;
            if (reg_we && reg_addr == A_HALF  && !running) htcnt_q <= reg_wdata;
            if (reg_we && reg_addr == A_IRQEN) begin
                tc_ie_q <= reg_wdata[0];
                ht_ie_q <= reg_wdata[1];
            end
            tc_q <= tc_set || (tc_q && !(clr_hit && reg_wdata[0]));
            ht_q <= ht_set || (ht_q && !(clr_hit && reg_wdata[1]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  begin
                reg_rdata[0]                 = running;
                reg_rdata[1 +: SRC_W]        = src_sel;
                reg_rdata[BANK_LSB +: BANK_W] = bank_sel;
            end
            A_TOTAL: reg_rdata = running ? remaining : cnt_q;
            A_HALF:  reg_rdata = running ? remaining : htcnt_q;
            A_IRQEN: reg_rdata[1:0] = {ht_ie_q, tc_ie_q};
            A_STAT:  reg_rdata[1:0] = {ht_q, tc_q};
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (tc_q && tc_ie_q) || (ht_q && ht_ie_q);

    AST_TOTAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(cnt_q)); // R7
    AST_HALF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(htcnt_q)); // R7
    AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_q && !(clr_hit && reg_wdata[0])) |=> tc_q); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_set |=> tc_q); // R8
endmodule

// File: rtl/bsdma_chan.sv
module bsdma_chan
    import bsdma_pkg::*;
#(
    parameter int unsigned CNT_W    = 28,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned NUM_BANK = 4,
    localparam int unsigned SRC_W   = $clog2(NUM_SRC),
    localparam int unsigned BANK_W  = $clog2(NUM_BANK)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [CNT_W-1:0]          reg_wdata,
    output logic [CNT_W-1:0]          reg_rdata,
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic [NUM_SRC-1:0]        src_ready,
    input  logic                      bus_ready,
    output logic                      bus_wr_en,
    output logic [DATA_W-1:0]         bus_wdata,
    output logic [NUM_BANK-1:0]       bank_strobe,
    output logic                      irq
);
    logic              running, beat, start_req, stop_req, tc_set, ht_set;
    logic [CNT_W-1:0]  cur_cnt, cnt_q, htcnt_q;
    logic [SRC_W-1:0]  src_sel;
    logic [BANK_W-1:0] bank_sel;

    bsdma_regs #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .NUM_BANK(NUM_BANK)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .running(running),
        .cur_cnt(cur_cnt), .tc_set(tc_set), .ht_set(ht_set),
        .start_req(start_req), .stop_req(stop_req), .src_sel(src_sel),
        .bank_sel(bank_sel), .cnt_q(cnt_q), .htcnt_q(htcnt_q), .irq(irq)
    );

    bsdma_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .beat(beat), .cnt(cnt_q), .htcnt(htcnt_q), .running(running),
        .cur_cnt(cur_cnt), .tc_set(tc_set), .ht_set(ht_set)
    );

    bsdma_route #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .NUM_BANK(NUM_BANK)) u_route (
        .clk(clk), .rst_n(rst_n), .running(running), .src_sel(src_sel),
        .bank_sel(bank_sel), .src_valid(src_valid), .src_data(src_data),
        .bus_ready(bus_ready), .beat(beat), .src_ready(src_ready),
        .bus_wdata(bus_wdata), .bank_strobe(bank_strobe)
    );

    assign bus_wr_en = beat;
endmodule

// File: tb/test_bsdma_chan.sv
module test_bsdma_chan;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [27:0] reg_wdata = '0;
    logic [27:0] reg_rdata;
    logic [1:0]  src_valid = 2'b00;
    logic [15:0] src_data = '0;
    logic [1:0]  src_ready;
    logic        bus_ready = 1'b0;
    logic        bus_wr_en;
    logic [7:0]  bus_wdata;
    logic [3:0]  bank_strobe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    bsdma_chan i_bsdma_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .bus_ready(bus_ready),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
        .bank_strobe(bank_strobe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [27:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [27:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_xfer(input int src, input int bank, input int cnt,
                           input logic [27:0] ht, input int vmod, input int rmod);
        int sent = 0;
        bit run_m = 1;
        logic [27:0] d;
        src_valid = 2'b00; bus_ready = 1'b0;
        wr(3'd1, 28'(cnt));
        wr(3'd2, ht);
        wr(3'd5, 28'h3);
        wr(3'd0, 28'((bank << 2) | (src << 1) | 1));
        for (int i = 0; i < 400 && run_m; i++) begin
            bit v, r, e;
            v = (vmod == 1) || (i % vmod != 0);
            r = (rmod == 1) || (i % rmod != 1);
            src_valid[src]     = v;
            src_valid[1 - src] = 1'b1;
            src_data[src*8 +: 8]       = 8'(8'h40 + sent);
            src_data[(1 - src)*8 +: 8] = 8'hEE;
            bus_ready = r;
            reg_addr  = 3'd1;
            #1;
            e = v && r;
            chk("R3 write", {31'b0, bus_wr_en}, {31'b0, e});
            chk("R7 remaining", {4'b0, reg_rdata}, 32'(cnt - sent));
            if (e) begin
                chk("R3 data", {24'b0, bus_wdata}, 32'(8'h40 + sent));
                chk("R4 strobe", {28'b0, bank_strobe}, 32'(1 << bank));
                chk("R3 ready", {30'b0, src_ready}, 32'(1 << src));
                sent++;
                if (sent == cnt + 1) run_m = 0;
            end else begin
                chk("R3 no ready", {30'b0, src_ready}, 32'd0);
            end
            @(negedge clk);
        end
        src_valid = 2'b00; bus_ready = 1'b0;
        chk("R5 bytes", 32'(sent), 32'(cnt + 1));
        rd(3'd0, d);
        chk("R5 enable clear", {31'b0, d[0]}, 32'd0);
        rd(3'd4, d);
        chk("R5 tc flag", {31'b0, d[0]}, 32'd1);
        chk("R6 ht flag", {31'b0, d[1]}, {31'b0, (ht <= 28'(cnt))});
        src_valid = 2'b11; bus_ready = 1'b1;
        #1;
        chk("R5 no extra", {31'b0, bus_wr_en}, 32'd0);
        @(negedge clk);
        src_valid = 2'b00; bus_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [27:0] d;
        rd(3'd0, d); chk("R1 ctrl", {4'b0, d}, 32'd0);
        rd(3'd1, d); chk("R1 total", {4'b0, d}, 32'd0);
        rd(3'd2, d); chk("R1 half", {4'b0, d}, 32'h0FFFFFFF);
        rd(3'd3, d); chk("R1 irqen", {4'b0, d}, 32'd0);
        rd(3'd4, d); chk("R1 flags", {4'b0, d}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        src_valid = 2'b11; bus_ready = 1'b1;
        #1;
        chk("R1 no write idle", {31'b0, bus_wr_en}, 32'd0);
        src_valid = 2'b00; bus_ready = 1'b0;
    endtask

    task automatic t_basic();
        logic [27:0] d;
        wr(3'd3, 28'h3);
        do_xfer(0, 2, 3, 28'd1, 3, 4);
        rd(3'd0, d); chk("R2 ctrl fields", {4'b0, d}, 32'h8);
        chk("R9 irq both", {31'b0, irq}, 32'd1);
    endtask

    task automatic t_clear();
        logic [27:0] d;
        wr(3'd3, 28'h1);
        wr(3'd5, 28'h1);
        rd(3'd4, d); chk("R8 clear tc", {4'b0, d}, 32'h2);
        chk("R9 ht masked", {31'b0, irq}, 32'd0);
        wr(3'd3, 28'h3);
        #1;
        chk("R9 ht enabled", {31'b0, irq}, 32'd1);
        wr(3'd5, 28'h0);
        rd(3'd4, d); chk("R8 zero no clear", {4'b0, d}, 32'h2);
        wr(3'd5, 28'h2);
        rd(3'd4, d); chk("R8 clear ht", {4'b0, d}, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_lock_abort();
        logic [27:0] d;
        wr(3'd1, 28'd9);
        wr(3'd2, 28'd20);
        wr(3'd0, 28'h3);
        for (int i = 0; i < 2; i++) begin
            src_valid = 2'b10; bus_ready = 1'b1; src_data = 16'h5500;
            @(negedge clk);
        end
        src_valid = 2'b00; bus_ready = 1'b0;
        rd(3'd1, d); chk("R7 remaining", {4'b0, d}, 32'd7);
        wr(3'd1, 28'd5);
        wr(3'd2, 28'd1);
        rd(3'd1, d); chk("R7 total locked", {4'b0, d}, 32'd7);
        rd(3'd2, d); chk("R7 half reads remaining", {4'b0, d}, 32'd7);
        wr(3'd0, 28'h0);
        rd(3'd0, d); chk("R10 enable off", {31'b0, d[0]}, 32'd0);
        rd(3'd4, d); chk("R10 no tc", {4'b0, d}, 32'd0);
        src_valid = 2'b11; bus_ready = 1'b1;
        #1;
        chk("R10 no write", {31'b0, bus_wr_en}, 32'd0);
        @(negedge clk);
        src_valid = 2'b00; bus_ready = 1'b0;
        rd(3'd1, d); chk("R7 total kept", {4'b0, d}, 32'd9);
        rd(3'd2, d); chk("R7 half kept", {4'b0, d}, 32'd20);
    endtask

    task automatic t_restart();
        do_xfer(0, 1, 4, 28'hFFFFFFF, 1, 1); // R11 full count after abort, R6 never fires
    endtask

    task automatic t_other_source();
        do_xfer(1, 3, 2, 28'd7, 2, 3);
    endtask

    task automatic t_same_cycle();
        logic [27:0] d;
        wr(3'd1, 28'd0);
        wr(3'd2, 28'd0);
        wr(3'd5, 28'h3);
        wr(3'd3, 28'h3);
        wr(3'd0, 28'h5);
        @(negedge clk);
        src_valid = 2'b01; bus_ready = 1'b1; src_data = 16'h00A7;
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 28'h3;
        #1;
        chk("R3 single write", {31'b0, bus_wr_en}, 32'd1);
        chk("R4 bank1", {28'b0, bank_strobe}, 32'h2);
        @(negedge clk);
        reg_we = 1'b0; src_valid = 2'b00; bus_ready = 1'b0;
        rd(3'd4, d); chk("R8 set wins both", {4'b0, d}, 32'h3);
        rd(3'd0, d); chk("R5 enable clear", {31'b0, d[0]}, 32'd0);
        chk("R9 irq", {31'b0, irq}, 32'd1);
        src_valid = 2'b01; bus_ready = 1'b1;
        #1;
        chk("R5 no extra", {31'b0, bus_wr_en}, 32'd0);
        @(negedge clk);
        src_valid = 2'b00; bus_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_lock_abort();
        t_restart();
        t_other_source();
        t_same_cycle();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule